// File: doc/BRIEF.md
# Registered-Ready Handshake Pipeline Stage

This block is one stage of a data pipeline that passes words from an upstream producer to a downstream consumer over four control wires. Its ready output is a promise about the next cycle: when `in_ready` is high, the producer is allowed to present a word in the following cycle. The producer must not raise `in_valid` in a cycle unless `in_ready` was high in the cycle before.

On the output side, `out_ready` is a one-cycle-delayed copy of the consumer's own ready. A high `out_ready` means the consumer takes a word in the current cycle. The stage raises `out_valid` only in a cycle where it holds a word and `out_ready` is high. That word is transferred in the same cycle, so no pending offer is ever held.

A two-entry buffer absorbs the one-cycle lag of the ready promise. Each accepted word passes through a fixed transform on its way into the buffer. A parameter selects the transform: either pass-through or add one.

Top module: `hs_node`

## Requirements
- R1: While `rst` is high, `in_ready` and `out_valid` are low. After `rst` falls the buffer is empty, so `out_valid` stays low even when `out_ready` is high.
- R2: `in_ready` is high exactly when fewer than DEPTH words will be held after the current cycle's accept and drain. With DEPTH=2, this means at most one word.
- R3: `in_ready` reacts in the same cycle to `in_valid`. With one word held and no drain, raising `in_valid` pulls `in_ready` low in that cycle.
- R4: `out_valid` is high only when at least one word is held and `out_ready` is high in the same cycle. With an empty buffer, `out_valid` is low whatever `out_ready` does.
- R5: `out_valid` follows `out_ready` combinationally within a cycle. If `out_ready` is toggled between clock edges, `out_valid` tracks it.
- R6: The stage accepts `in_data` on every cycle in which `in_valid` is high. A producer that obeys the rule on `in_ready` never finds the buffer full.
- R7: Words leave in the order they entered, each exactly once. A held word stays at `out_data` until a cycle with `out_valid` high removes it.
- R8: With MODE=XF_INC, `out_data` equals the accepted `in_data` plus one, modulo 2^DATA_W, so 0xFF becomes 0x00. With MODE=XF_PASS, `out_data` is unchanged.
- R9: The number of held words never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer presents a word this cycle |
| in_data | input | DATA_W | Word from the producer |
| in_ready | output | 1 | Stage can take a word next cycle |
| out_valid | output | 1 | Word transferred to the consumer this cycle |
| out_data | output | DATA_W | Word at the head of the buffer |
| out_ready | input | 1 | Delayed consumer ready: consumer takes a word this cycle |

## Verification
The bench builds the stage with DATA_W=8, DEPTH=2 and MODE=XF_INC. The increment mode makes every output word differ from its input, so a word that bypasses the buffer or is duplicated shows up as a mismatch. An 8-bit width puts the wrap from 0xFF to 0x00 within reach of a short directed sequence. A depth of two allows both the full and the empty boundary to be reached within a few cycles. Random producer and consumer patterns then exercise ordering under arbitrary stalls.

// File: rtl/hs_node_pkg.sv
`timescale 1ns/1ps
package hs_node_pkg;

    // Transform applied to each word as it enters the buffer
    typedef enum logic {
        XF_PASS = 1'b0,
        XF_INC  = 1'b1
    } xform_e;

    // Buffer commands issued by the control logic each cycle
    typedef struct packed {
        logic wr;   // store the incoming word
        logic rd;   // retire the head word
    } buf_cmd_t;

endpackage

// File: rtl/hs_node_ctrl.sv
`timescale 1ns/1ps
module hs_node_ctrl
    import hs_node_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     out_ready,
    output logic     in_ready,
    output logic     out_valid,
    output buf_cmd_t cmd
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;

    always_comb begin
        out_valid = !rst && (cnt_q != '0) && out_ready;
        cmd.wr    = !rst && in_valid;
        cmd.rd    = out_valid;
        cnt_next  = {1'b0, cnt_q} + (CNT_W + 1)'(cmd.wr) - (CNT_W + 1)'(cmd.rd);
        // promise for next cycle: room must remain after this cycle settles
        in_ready  = !rst && (cnt_next < LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next[CNT_W-1:0];
    end

    // R9: occupancy bounded
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R2: a promise of readiness leaves at least one free entry
    p_ready_promise_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> (cnt_q < CNT_W'(DEPTH)));

    // R6: producer only sends after a promise in the previous cycle
    p_upstream_rule_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $past(in_ready));

    // R4: no offer without the consumer being ready
    p_valid_needs_ready_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ready);

endmodule

// File: rtl/hs_node_store.sv
`timescale 1ns/1ps
module hs_node_store
    import hs_node_pkg::*;
#(
    parameter int     DATA_W = 8,
    parameter int     DEPTH  = 2,
    parameter xform_e MODE   = XF_INC
) (
    input  logic              clk,
    input  logic              rst,
    input  buf_cmd_t          cmd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DATA_W-1:0] xf_data;

    generate
        if (MODE == XF_INC) begin : g_inc
            assign xf_data = wr_data + DATA_W'(1);
        end else begin : g_pass
            assign xf_data = wr_data;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (cmd.wr) mem[wr_ptr] <= xf_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (cmd.wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (cmd.rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

    assign rd_data = mem[rd_ptr];

    // R7: head pointer moves only on a retire
    p_head_moves_on_rd_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd.rd |=> $stable(rd_ptr));

endmodule

// File: rtl/hs_node.sv
`timescale 1ns/1ps
module hs_node
    import hs_node_pkg::*;
#(
    parameter int     DATA_W = 8,
    parameter int     DEPTH  = 2,
    parameter xform_e MODE   = XF_INC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    buf_cmd_t cmd;

    hs_node_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .cmd       (cmd)
    );

    hs_node_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(MODE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wr_data (in_data),
        .rd_data (out_data)
    );

    // R7: with no traffic at either side the head word holds
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> $stable(out_data));

endmodule

// File: tb/sim_hs_node.sv
`timescale 1ns/1ps
module sim_hs_node;
    import hs_node_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hs_node #(.DATA_W(8), .DEPTH(2), .MODE(XF_INC)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    // row: {vld, din[7:0], ordy, exp_ovld, exp_dout[7:0], exp_irdy}
    localparam logic [19:0] VEC [12] = '{
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h10, 1'b0, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h11, 1'b1},
        {1'b1, 8'hFF, 1'b1, 1'b1, 8'h21, 1'b1},
        {1'b1, 8'h30, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1},
        {1'b1, 8'h40, 1'b1, 1'b1, 8'h31, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h41, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
        {1'b1, 8'h50, 1'b1, 1'b0, 8'h00, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] q[$];
        logic       prev_rdy;
        logic       exp_ov, exp_ir;

        // R1: outputs during reset
        repeat (2) @(posedge clk);
        #2;
        out_ready = 1'b1;
        #1;
        check("R1 in_ready in reset", 32'(in_ready), 0);
        check("R1 out_valid in reset", 32'(out_valid), 0);
        out_ready = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;

        // table walk: R2 R3 R4 R6 R7 R8
        for (int i = 0; i < 12; i++) begin
            if (i > 0) begin @(posedge clk); #1; end
            in_valid  = VEC[i][19];
            in_data   = VEC[i][18:11];
            out_ready = VEC[i][10];
            #2;
            check($sformatf("R2/R3 in_ready row %0d", i), 32'(in_ready), 32'(VEC[i][0]));
            check($sformatf("R4 out_valid row %0d", i), 32'(out_valid), 32'(VEC[i][9]));
            if (VEC[i][9])
                check($sformatf("R7/R8 out_data row %0d", i), 32'(out_data), 32'(VEC[i][8:1]));
        end
        // buffer holds 0x51

        // R5: toggle out_ready within one cycle, no edge in between
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 1'b0;
        #1; check("R5 out_valid low with ready low", 32'(out_valid), 0);
        out_ready = 1'b1;
        #1; check("R5 out_valid follows ready", 32'(out_valid), 1);
        check("R5 head word", 32'(out_data), 32'h51);
        out_ready = 1'b0;
        #1; check("R5 out_valid drops with ready", 32'(out_valid), 0);
        // R7: word not consumed, still present next cycle
        @(posedge clk); #1;
        out_ready = 1'b1;
        #1; check("R7 word kept after withdrawn ready", 32'(out_valid), 1);
        check("R7 word value kept", 32'(out_data), 32'h51);

        // R1: reset with data held empties the buffer
        @(posedge clk); #1;
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h60;
        @(posedge clk); #1;
        in_valid = 1'b0; rst = 1'b1; out_ready = 1'b1;
        #1;
        check("R1 in_ready during reset", 32'(in_ready), 0);
        check("R1 out_valid during reset", 32'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        #1;
        check("R1 empty after reset", 32'(out_valid), 0);
        check("R1 ready after reset", 32'(in_ready), 1);
        prev_rdy = in_ready;

        // random traffic: R2 R4 R6 R7 R8 R9
        for (int c = 0; c < 3000; c++) begin
            @(posedge clk); #1;
            in_valid  = prev_rdy && ($urandom_range(0, 3) != 0);
            in_data   = 8'($urandom);
            out_ready = ($urandom_range(0, 2) != 0);
            #2;
            exp_ov = (q.size() > 0) && out_ready;
            exp_ir = (q.size() + int'(in_valid) - int'(exp_ov)) < 2;
            check("R4 random out_valid", 32'(out_valid), 32'(exp_ov));
            check("R2 random in_ready", 32'(in_ready), 32'(exp_ir));
            if (exp_ov) begin
                check("R7/R8 random order", 32'(out_data), 32'(q[0]));
                void'(q.pop_front());
            end
            if (in_valid) q.push_back(in_data + 8'd1);
            check("R9 model occupancy", 32'(q.size() <= 2), 1);
            prev_rdy = in_ready;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule